// File: doc/BRIEF.md
# Tagged Write Data Beat Engine

This block runs the data phase of write transactions for up to sixteen transfers in flight at once. Each transfer is named by a 4-bit tag. When a write request and its acknowledge are both high in a cycle, the block stores three things in that tag's context: the 128-bit payload, the beat count and the tag. From the next cycle on it sends 8-bit beats for the transfer in order, with the most significant payload byte first. Each beat carries a valid strobe, the tag and a final-beat flag. When several tags hold beats, a round-robin arbiter grants one beat per cycle.

A retry input, qualified by its own tag, abandons the current pass of that transaction. The whole transfer is then sent again from the first byte, with no new request and the same tag. A retry is honoured from acceptance up to and including the cycle after the final beat. For that reason completion is reported in the cycle after the final beat, and only when no retry for that tag arrives in the same cycle.

Each tag context is a small state machine with three states. `CTX_IDLE` holds no transfer. `CTX_SEND` has beats still to send. `CTX_WINDOW` is the single cycle after the final beat, in which a retry can still rewind the transfer. Its transitions are:
- load: IDLE to SEND, on an accepted request for a free tag.
- advance: SEND to SEND, when a beat is granted and it is not the final beat.
- finish: SEND to WINDOW, when the final beat is granted.
- rewind: SEND or WINDOW to SEND with the beat index at 0, on a retry for the tag.
- complete: WINDOW to IDLE, when no retry for the tag arrives.

Top module: `tagged_beat_engine`

## Requirements
- R1: A transaction is accepted when `wr_req_i` and `wr_ack_i` are both high at a clock edge and the tag on `ack_tag_i` is free. The first beat for that tag can appear at the outputs from the following cycle.
- R2: Beats of one transaction are sent in order, one per grant. Beat k carries payload bits [127-8k : 120-8k], so beat 0 is the most significant byte.
- R3: `beat_cnt_i` encodes the number of beats minus one, so 0 means 1 beat and 15 means 16 beats. `beat_last_o` is high together with `beat_vld_o` exactly on the final beat.
- R4: In the cycle after a tag's final beat, `done_o` is high with `done_tag_o` equal to that tag, unless a retry for the same tag is present in that cycle.
- R5: A retry for a tag that is sending aborts its progress, including a beat shown in the same cycle. The next beat sent for that tag is beat 0.
- R6: A retry in the cycle after the final beat suppresses `done_o` in that cycle, and the whole transfer is sent again from beat 0.
- R7: When several tags have beats pending, the grant goes to the first pending tag in ascending order, wrapping around, starting after the tag served last. After reset the search starts at tag 0.
- R8: An accepted request that names a tag already holding a transfer sets the sticky flag `err_o` from the next cycle. That request is ignored, and the existing transfer's beats are unchanged.
- R9: A retry for a tag that holds no transfer has no effect: no beats and no completion follow from it.
- R10: A synchronous active-high `rst` clears every tag context and `err_o`. After it, no beats and no completions appear until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | 1 | Write request |
| wr_ack_i | input | 1 | Request acknowledge; with `wr_req_i` it accepts a transaction |
| ack_tag_i | input | 4 | Tag assigned to the accepted transaction |
| payload_i | input | 128 | Payload; most significant byte is beat 0 |
| beat_cnt_i | input | 4 | Number of beats minus one |
| retry_i | input | 1 | Retry strobe |
| retry_tag_i | input | 4 | Tag that the retry applies to |
| beat_vld_o | output | 1 | A beat is shown this cycle |
| beat_tag_o | output | 4 | Tag of the shown beat |
| beat_data_o | output | 8 | Beat data |
| beat_last_o | output | 1 | Final beat of the transaction |
| done_o | output | 1 | A transaction completes this cycle |
| done_tag_o | output | 4 | Tag of the completing transaction |
| err_o | output | 1 | Sticky flag: a request named a busy tag |

## Verification
The bench sends a retry in the same cycle as a mid-transfer beat. A design that let that beat advance would resume at beat 2 instead of beat 0. A second test sends a retry in the window cycle after the final beat. There, a design that closed completion too early would pulse `done_o` and drop the resend. An interleaving test runs two tags together and checks the alternating order and a completion that overlaps the other tag's final beat. A design with fixed priority or a stale arbiter pointer would starve one tag or repeat a tag. Further tests cover:
- a duplicate tag on a live transfer, which a faulty design would let overwrite the payload;
- a retry naming an idle tag or another tag, which must disturb nothing;
- the sixteen-beat and one-beat extremes, where an off-by-one beat count would misplace the final flag.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
    typedef enum logic [1:0] {
        CTX_IDLE   = 2'd0,
        CTX_SEND   = 2'd1,
        CTX_WINDOW = 2'd2
    } ctx_state_e;
endpackage

// File: rtl/tbe_rr_arb.sv
module tbe_rr_arb #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cand;

    // Search starts one past the tag served last and wraps around.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = last_q;
        cand    = last_q;
        for (int k = 1; k <= N; k++) begin
            cand = IDX_W'((int'(last_q) + k) % N);
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(N - 1);
        end else if (gnt_vld) begin
            last_q <= gnt_idx;
        end
    end

    // R7: a grant always targets a requesting tag.
    p_grant_requested_r7: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);
    // R7: the tag just served is not served again while another waits.
    p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && ($countones(req) > 1)) |-> (gnt_idx != last_q));
endmodule

// File: rtl/tbe_tag_ctx.sv
module tbe_tag_ctx
    import tbe_pkg::*;
#(
    parameter int BEAT_W    = 8,
    parameter int MAX_BEATS = 16,
    parameter int PAYLOAD_W = BEAT_W * MAX_BEATS,
    parameter int CNT_W     = $clog2(MAX_BEATS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [CNT_W-1:0]     cnt_m1,
    input  logic                 retry_hit,
    input  logic                 grant,
    output logic                 pending,
    output logic                 busy,
    output logic                 fin,
    output logic [BEAT_W-1:0]    cur_byte,
    output logic                 cur_last
);
    ctx_state_e           state_q, state_d;
    logic [PAYLOAD_W-1:0] pay_q;
    logic [CNT_W-1:0]     nm1_q;
    logic [CNT_W-1:0]     idx_q, idx_d;
    logic                 at_last;

    assign at_last = (idx_q == nm1_q);

    // Next-state and index selection.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            CTX_IDLE: begin
                if (load) begin
                    state_d = CTX_SEND;
                    idx_d   = '0;
                end
            end
            CTX_SEND: begin
                if (retry_hit) begin
                    idx_d = '0;
                end else if (grant && at_last) begin
                    state_d = CTX_WINDOW;
                end else if (grant) begin
                    idx_d = idx_q + 1'b1;
                end
            end
            CTX_WINDOW: begin
                if (retry_hit) begin
                    state_d = CTX_SEND;
                    idx_d   = '0;
                end else begin
                    state_d = CTX_IDLE;
                end
            end
            default: state_d = CTX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTX_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Context storage, written only on load.
    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q <= '0;
            nm1_q <= '0;
        end else if (load && state_q == CTX_IDLE) begin
            pay_q <= payload;
            nm1_q <= cnt_m1;
        end
    end

    // Outputs.
    always_comb begin
        pending  = (state_q == CTX_SEND);
        busy     = (state_q != CTX_IDLE);
        fin      = (state_q == CTX_WINDOW) && !retry_hit;
        cur_byte = pay_q[PAYLOAD_W - 1 - int'(idx_q) * BEAT_W -: BEAT_W];
        cur_last = at_last;
    end

    // R4: the retry window lasts a single cycle.
    p_window_single_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_WINDOW) |=> (state_q != CTX_WINDOW));
    // R5: a retry on an active context rewinds it to beat zero.
    p_rewind_r5: assert property (@(posedge clk) disable iff (rst)
        (retry_hit && state_q != CTX_IDLE) |=> (state_q == CTX_SEND && idx_q == '0));
    // R9: a retry on an idle context leaves it idle.
    p_idle_retry_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_IDLE && !load && retry_hit) |=> (state_q == CTX_IDLE));
    // R2: beats advance by exactly one per grant.
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_SEND && grant && !retry_hit && !at_last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/tagged_beat_engine.sv
module tagged_beat_engine
    import tbe_pkg::*;
#(
    parameter int NUM_TAGS  = 16,
    parameter int BEAT_W    = 8,
    parameter int MAX_BEATS = 16,
    parameter int TAG_W     = $clog2(NUM_TAGS),
    parameter int CNT_W     = $clog2(MAX_BEATS),
    parameter int PAYLOAD_W = BEAT_W * MAX_BEATS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_req_i,
    input  logic                 wr_ack_i,
    input  logic [TAG_W-1:0]     ack_tag_i,
    input  logic [PAYLOAD_W-1:0] payload_i,
    input  logic [CNT_W-1:0]     beat_cnt_i,
    input  logic                 retry_i,
    input  logic [TAG_W-1:0]     retry_tag_i,
    output logic                 beat_vld_o,
    output logic [TAG_W-1:0]     beat_tag_o,
    output logic [BEAT_W-1:0]    beat_data_o,
    output logic                 beat_last_o,
    output logic                 done_o,
    output logic [TAG_W-1:0]     done_tag_o,
    output logic                 err_o
);
    logic                accept;
    logic [NUM_TAGS-1:0] load_v, retry_v, grant_v;
    logic [NUM_TAGS-1:0] pend_v, busy_v, fin_v, last_v;
    logic [BEAT_W-1:0]   byte_a [NUM_TAGS];
    logic                gnt_vld;
    logic [TAG_W-1:0]    gnt_idx;
    logic                err_q;

    assign accept = wr_req_i && wr_ack_i;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_ctx
        assign load_v[t]  = accept && (ack_tag_i == TAG_W'(t)) && !busy_v[t];
        assign retry_v[t] = retry_i && (retry_tag_i == TAG_W'(t));
        assign grant_v[t] = gnt_vld && (gnt_idx == TAG_W'(t));

        tbe_tag_ctx #(
            .BEAT_W    (BEAT_W),
            .MAX_BEATS (MAX_BEATS),
            .PAYLOAD_W (PAYLOAD_W),
            .CNT_W     (CNT_W)
        ) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .load      (load_v[t]),
            .payload   (payload_i),
            .cnt_m1    (beat_cnt_i),
            .retry_hit (retry_v[t]),
            .grant     (grant_v[t]),
            .pending   (pend_v[t]),
            .busy      (busy_v[t]),
            .fin       (fin_v[t]),
            .cur_byte  (byte_a[t]),
            .cur_last  (last_v[t])
        );
    end

    tbe_rr_arb #(
        .N     (NUM_TAGS),
        .IDX_W (TAG_W)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (pend_v),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    // Sticky duplicate-tag flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (accept && busy_v[ack_tag_i]) begin
            err_q <= 1'b1;
        end
    end

    // Beat and completion outputs.
    always_comb begin
        beat_vld_o  = gnt_vld;
        beat_tag_o  = gnt_idx;
        beat_data_o = byte_a[gnt_idx];
        beat_last_o = gnt_vld && last_v[gnt_idx];
        done_o      = |fin_v;
        done_tag_o  = '0;
        for (int t = 0; t < NUM_TAGS; t++) begin
            if (fin_v[t]) begin
                done_tag_o = TAG_W'(t);
            end
        end
        err_o = err_q;
    end

    // R4: at most one completion per cycle.
    p_one_done_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fin_v));
    // R6: a completion never coincides with a retry for its tag.
    p_done_no_retry_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(retry_i && retry_tag_i == done_tag_o));
    // R8: the duplicate-tag flag stays set until reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    // R10: after reset there are no beats and no flag.
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!beat_vld_o && !err_o && !done_o));
    // R3: the final-beat flag only travels with a valid beat.
    p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
        beat_last_o |-> beat_vld_o);
endmodule

// File: tb/tagged_beat_engine_tb.sv
module tagged_beat_engine_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         wr_req_i, wr_ack_i;
    logic [3:0]   ack_tag_i;
    logic [127:0] payload_i;
    logic [3:0]   beat_cnt_i;
    logic         retry_i;
    logic [3:0]   retry_tag_i;
    logic         beat_vld_o;
    logic [3:0]   beat_tag_o;
    logic [7:0]   beat_data_o;
    logic         beat_last_o;
    logic         done_o;
    logic [3:0]   done_tag_o;
    logic         err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tagged_beat_engine u_dut (
        .clk(clk), .rst(rst), .wr_req_i(wr_req_i), .wr_ack_i(wr_ack_i),
        .ack_tag_i(ack_tag_i), .payload_i(payload_i), .beat_cnt_i(beat_cnt_i),
        .retry_i(retry_i), .retry_tag_i(retry_tag_i), .beat_vld_o(beat_vld_o),
        .beat_tag_o(beat_tag_o), .beat_data_o(beat_data_o), .beat_last_o(beat_last_o),
        .done_o(done_o), .done_tag_o(done_tag_o), .err_o(err_o)
    );

    // Vector table: {tag, beats-1, seed}.
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0,  4'd0,  8'h5A},
        {4'd1,  4'd3,  8'h10},
        {4'd15, 4'd15, 8'hC3},
        {4'd8,  4'd7,  8'h01},
        {4'd4,  4'd1,  8'hFE},
        {4'd10, 4'd0,  8'h77}
    };

    function automatic logic [7:0] exp_byte(input logic [7:0] seed, input int k);
        return seed + 8'(k * 8'h13);
    endfunction

    function automatic logic [127:0] mk_payload(input logic [7:0] seed);
        logic [127:0] p;
        for (int k = 0; k < 16; k++) p[127 - 8*k -: 8] = exp_byte(seed, k);
        return p;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic check_beat(input string what, input logic [3:0] tag,
                              input logic [7:0] data, input logic last);
        check({what, " vld"},  32'(beat_vld_o), 32'd1);
        check({what, " tag"},  32'(beat_tag_o), 32'(tag));
        check({what, " data"}, 32'(beat_data_o), 32'(data));
        check({what, " last"}, 32'(beat_last_o), 32'(last));
    endtask

    task automatic accept(input logic [3:0] tag, input logic [3:0] nm1, input logic [7:0] seed);
        wr_req_i = 1'b1; wr_ack_i = 1'b1; ack_tag_i = tag;
        beat_cnt_i = nm1; payload_i = mk_payload(seed);
    endtask

    task automatic idle_in();
        wr_req_i = 1'b0; wr_ack_i = 1'b0; retry_i = 1'b0;
    endtask

    // Single transaction from acceptance through completion.
    task automatic run_txn(input logic [3:0] tag, input logic [3:0] nm1, input logic [7:0] seed);
        accept(tag, nm1, seed);
        @(negedge clk); idle_in();
        for (int k = 0; k <= int'(nm1); k++) begin
            #1 check_beat("R1 R2 R3 table beat", tag, exp_byte(seed, k), k == int'(nm1));
            @(negedge clk);
        end
        #1;
        check("R4 table done", 32'(done_o), 32'd1);
        check("R4 table done_tag", 32'(done_tag_o), 32'(tag));
        check("R4 table no beat after", 32'(beat_vld_o), 32'd0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; idle_in(); ack_tag_i = '0; payload_i = '0;
        beat_cnt_i = '0; retry_tag_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset beat_vld", 32'(beat_vld_o), 32'd0);
        check("R10 reset done", 32'(done_o), 32'd0);
        check("R10 reset err", 32'(err_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) run_txn(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0]);

        // R5: retry in the same cycle as beat 1 rewinds to beat 0.
        accept(4'd3, 4'd3, 8'h20);
        @(negedge clk); idle_in();
        #1 check_beat("R5 first beat0", 4'd3, exp_byte(8'h20, 0), 1'b0);
        @(negedge clk);
        #1 check_beat("R5 beat1", 4'd3, exp_byte(8'h20, 1), 1'b0);
        retry_i = 1'b1; retry_tag_i = 4'd3;
        @(negedge clk); retry_i = 1'b0;
        #1 check_beat("R5 rewound beat0", 4'd3, exp_byte(8'h20, 0), 1'b0);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            #1 check_beat("R5 resend", 4'd3, exp_byte(8'h20, k), k == 3);
        end
        @(negedge clk);
        #1 check("R5 done", 32'(done_o), 32'd1);
        @(negedge clk);

        // R6: retry in the window cycle suppresses completion.
        accept(4'd5, 4'd1, 8'h40);
        @(negedge clk); idle_in();
        #1 check_beat("R6 beat0", 4'd5, exp_byte(8'h40, 0), 1'b0);
        @(negedge clk);
        #1 check_beat("R6 beat1", 4'd5, exp_byte(8'h40, 1), 1'b1);
        @(negedge clk);
        retry_i = 1'b1; retry_tag_i = 4'd5;
        #1 check("R6 done held back", 32'(done_o), 32'd0);
        @(negedge clk); retry_i = 1'b0;
        #1 check_beat("R6 resend beat0", 4'd5, exp_byte(8'h40, 0), 1'b0);
        @(negedge clk);
        #1 check_beat("R6 resend beat1", 4'd5, exp_byte(8'h40, 1), 1'b1);
        @(negedge clk);
        #1 check("R6 final done", 32'(done_o), 32'd1);
        check("R6 final done_tag", 32'(done_tag_o), 32'd5);
        @(negedge clk);

        // R7: two tags interleave in round-robin order.
        accept(4'd2, 4'd3, 8'h60);
        @(negedge clk);
        accept(4'd9, 4'd3, 8'h90);
        for (int j = 0; j < 8; j++) begin
            #1 check_beat("R7 interleave", (j % 2 == 0) ? 4'd2 : 4'd9,
                          exp_byte((j % 2 == 0) ? 8'h60 : 8'h90, j / 2), (j / 2) == 3);
            if (j == 7) begin
                check("R7 done tag2 overlap", 32'(done_o), 32'd1);
                check("R7 done_tag overlap", 32'(done_tag_o), 32'd2);
            end
            @(negedge clk); idle_in();
        end
        #1 check("R7 done tag9", 32'(done_tag_o), 32'd9);
        check("R7 done tag9 strobe", 32'(done_o), 32'd1);
        @(negedge clk);

        // R8: duplicate tag is flagged and ignored.
        accept(4'd7, 4'd2, 8'hA0);
        @(negedge clk);
        accept(4'd7, 4'd0, 8'h33);
        #1 check_beat("R8 beat0", 4'd7, exp_byte(8'hA0, 0), 1'b0);
        @(negedge clk); idle_in();
        #1 check("R8 err set", 32'(err_o), 32'd1);
        check_beat("R8 beat1 unchanged", 4'd7, exp_byte(8'hA0, 1), 1'b0);
        @(negedge clk);
        #1 check_beat("R8 beat2 unchanged", 4'd7, exp_byte(8'hA0, 2), 1'b1);
        @(negedge clk);
        #1 check("R8 done", 32'(done_o), 32'd1);
        check("R8 err still set", 32'(err_o), 32'd1);

        // R9: retry on an idle tag, and on another tag, changes nothing.
        retry_i = 1'b1; retry_tag_i = 4'd11;
        @(negedge clk); retry_i = 1'b0;
        #1 check("R9 idle retry no beat", 32'(beat_vld_o), 32'd0);
        check("R9 idle retry no done", 32'(done_o), 32'd0);
        accept(4'd1, 4'd1, 8'h0F);
        @(negedge clk); idle_in();
        #1 check_beat("R9 beat0", 4'd1, exp_byte(8'h0F, 0), 1'b0);
        retry_i = 1'b1; retry_tag_i = 4'd12;
        @(negedge clk); retry_i = 1'b0;
        #1 check_beat("R9 foreign retry beat1", 4'd1, exp_byte(8'h0F, 1), 1'b1);
        @(negedge clk);
        #1 check("R9 done", 32'(done_o), 32'd1);
        @(negedge clk);

        // R10: reset during a transfer clears everything.
        accept(4'd6, 4'd5, 8'hB0);
        @(negedge clk); idle_in();
        #1 check_beat("R10 beat0 before reset", 4'd6, exp_byte(8'hB0, 0), 1'b0);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R10 no beat after reset", 32'(beat_vld_o), 32'd0);
        check("R10 err cleared", 32'(err_o), 32'd0);
        @(negedge clk);
        #1 check("R10 still quiet", 32'(beat_vld_o), 32'd0);
        check("R10 no done", 32'(done_o), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule